// File: doc/BRIEF.md
# Register Rename Map and Free List

This block is the renaming step placed between instruction decode and the register-file read. It handles one instruction per cycle. The instruction brings two architectural source numbers and an optional architectural destination. The block returns three things: the physical register currently holding each source, a physical register taken fresh from a hardware free list for the destination, and the physical register that destination held before. Commit logic keeps that previous mapping and later hands it back through the release port, which returns it to the free list.

Every destination gets a physical register that no other instruction in flight holds. This removes write-after-read and write-after-write conflicts between instructions that reuse the same architectural register. Downstream logic sees only physical numbers. When no free register is left and the instruction needs one, the block raises a stall and changes no state. The producer then holds the instruction and presents it again.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i, so an instruction whose sources are a and b returns physical sources a and b.
- R2: Sources are looked up in the map before the same instruction's destination update takes effect. An instruction that reads and writes register x sees x's old physical register, and the next instruction sees the new one.
- R3: Destinations are allocated from the free list in first-in first-out order. The list initially holds physical registers 32 to 63, in ascending order.
- R4: For each renamed destination, out_pold reports the physical register that the destination mapped to just before this instruction. It always differs from out_pdst.
- R5: Architectural register 0 is never renamed. A destination of 0 (or dst_en low) gives out_dst_en=0, out_pdst=0 and out_pold=0, takes nothing from the free list and leaves the map unchanged. Source 0 always returns physical 0.
- R6: When in_valid=1, the instruction has a nonzero destination and the free list is empty, stall is high in that same cycle (combinational), the instruction is not accepted (out_valid=0 the next cycle), and neither the map nor the free list changes.
- R7: A physical register given on the release port (rel_valid=1) is appended to the tail of the free list at the clock edge, so it is handed out after every register already on the list. Release works in the same cycle as an allocation, and also while the list is empty.
- R8: Outputs are registered: an instruction accepted at clock edge k appears with out_valid=1 right after edge k. out_valid is 0 after any edge at which in_valid was 0 or stall was 1, and 0 after reset.
- R9: An instruction without a destination is accepted even when the free list is empty (stall stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| src_a | input | 5 | First architectural source |
| src_b | input | 5 | Second architectural source |
| dst_en | input | 1 | Instruction writes a destination |
| dst | input | 5 | Architectural destination |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | 6 | Physical register being returned |
| stall | output | 1 | Instruction not accepted: no free register |
| out_valid | output | 1 | Renamed instruction on the outputs |
| out_psrc_a | output | 6 | Physical register for src_a |
| out_psrc_b | output | 6 | Physical register for src_b |
| out_dst_en | output | 1 | A physical destination was allocated |
| out_pdst | output | 6 | Newly allocated physical destination |
| out_pold | output | 6 | Previous physical mapping of the destination |

## Verification
Directed cases come first. One reads two registers right after reset to show the identity map. One instruction reads and writes the same register, which shows the lookup-before-update order. One instruction writes register 0, which must consume no free entry. A drain with no releases runs until stall rises. That drain separates a correct empty check from one that lets the list underflow. It also shows that instructions without a destination still pass while the list is empty. One release after the drain must be the very next register handed out, which tells FIFO order apart from any other reuse order. The rest is a seeded random mix: sources, destinations (including 0) and releases of previously superseded registers, with releases often in the same cycle as allocations. Each output field is compared against a bench model of the map and the queue.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int ARCH_REGS_DEF = 32;
  localparam int PHYS_REGS_DEF = 64;

  // Width of an index able to address n entries (at least one bit).
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rename_map.sv
module rename_map #(
  parameter int ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
  parameter int PHYS_REGS = rename_pkg::PHYS_REGS_DEF,
  localparam int AW = rename_pkg::idx_w(ARCH_REGS),
  localparam int PW = rename_pkg::idx_w(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_d,
  output logic [PW-1:0] rd_a,
  output logic [PW-1:0] rd_b,
  output logic [PW-1:0] rd_d,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata
);
  logic [PW-1:0] tbl [ARCH_REGS];

  // Asynchronous reads return the mapping as it stood before this edge's write.
  assign rd_a = tbl[ra_a];
  assign rd_b = tbl[ra_b];
  assign rd_d = tbl[ra_d];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) tbl[i] <= PW'(i);
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  // R5: entry zero is never overwritten
  p_no_zero_write_r5: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != '0));
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int DEPTH = 32,
  parameter int PW    = 6,
  parameter int BASE  = 32,
  localparam int HW   = rename_pkg::idx_w(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [PW-1:0] pop_data,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_data
);
  logic [PW-1:0] mem [DEPTH];
  logic [HW-1:0] head, tail;
  logic [CW-1:0] count;

  function automatic logic [HW-1:0] bump(input logic [HW-1:0] p);
    return (p == HW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_data = mem[head];
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PW'(BASE + i);
      head  <= '0;
      tail  <= '0;
      count <= CW'(DEPTH);
    end else begin
      if (push) begin
        mem[tail] <= push_data;
        tail      <= bump(tail);
      end
      if (pop) head <= bump(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R6: no allocation from an empty list
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
  // R7: a release never overruns the list
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CW'(DEPTH)));
  // R7: a release alone grows the count by one
  p_push_grows_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int ARCH_REGS = rename_pkg::ARCH_REGS_DEF,
  parameter int PHYS_REGS = rename_pkg::PHYS_REGS_DEF,
  localparam int AW = rename_pkg::idx_w(ARCH_REGS),
  localparam int PW = rename_pkg::idx_w(PHYS_REGS),
  localparam int FREE_REGS = PHYS_REGS - ARCH_REGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          dst_en,
  input  logic [AW-1:0] dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_preg,
  output logic          stall,
  output logic          out_valid,
  output logic [PW-1:0] out_psrc_a,
  output logic [PW-1:0] out_psrc_b,
  output logic          out_dst_en,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold
);
  logic          needs_dst, accept, take;
  logic          fl_empty;
  logic [PW-1:0] fl_head;
  logic [PW-1:0] map_a, map_b, map_d;

  assign needs_dst = dst_en && (dst != '0);
  assign stall     = in_valid && needs_dst && fl_empty;
  assign accept    = in_valid && !stall;
  assign take      = accept && needs_dst;

  rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst(rst),
    .ra_a(src_a), .ra_b(src_b), .ra_d(dst),
    .rd_a(map_a), .rd_b(map_b), .rd_d(map_d),
    .we(take), .waddr(dst), .wdata(fl_head)
  );

  rename_freelist #(.DEPTH(FREE_REGS), .PW(PW), .BASE(ARCH_REGS)) u_free (
    .clk(clk), .rst(rst),
    .pop(take), .pop_data(fl_head), .empty(fl_empty),
    .push(rel_valid), .push_data(rel_preg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_psrc_a <= '0;
      out_psrc_b <= '0;
      out_dst_en <= 1'b0;
      out_pdst   <= '0;
      out_pold   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_psrc_a <= map_a;
        out_psrc_b <= map_b;
        out_dst_en <= needs_dst;
        out_pdst   <= needs_dst ? fl_head : '0;
        out_pold   <= needs_dst ? map_d : '0;
      end
    end
  end

  // R6: a stalled instruction never shows up on the outputs
  p_stall_drops_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_valid);
  // R8: no input, no output
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4: the fresh register differs from the one it supersedes
  p_fresh_differs_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_en) |-> (out_pdst != out_pold));
  // R5: register 0 as destination allocates nothing
  p_zero_dst_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst == '0) |=> !out_dst_en);
endmodule

// File: tb/sim_reg_rename.sv
`timescale 1ns/1ps
module sim_reg_rename;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, dst_en = 1'b0, rel_valid = 1'b0;
  logic [4:0] src_a = '0, src_b = '0, dst = '0;
  logic [5:0] rel_preg = '0;
  logic stall, out_valid, out_dst_en;
  logic [5:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

  always #2 clk = ~clk;

  reg_rename u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .dst_en(dst_en), .dst(dst), .rel_valid(rel_valid), .rel_preg(rel_preg),
    .stall(stall), .out_valid(out_valid), .out_psrc_a(out_psrc_a),
    .out_psrc_b(out_psrc_b), .out_dst_en(out_dst_en), .out_pdst(out_pdst),
    .out_pold(out_pold)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int mmap [32];
  int fq [32];
  int fh, ft, fc;
  int pool [64];
  int pool_n;
  int last_pdst;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin mmap[i] = i; fq[i] = 32 + i; end
    fh = 0; ft = 0; fc = 32; pool_n = 0;
  endtask

  // One cycle: drive at negedge, check stall, clock, check registered outputs.
  task automatic step(input bit iv, input int a, input int b, input bit de,
                      input int d, input bit rv, input int rp);
    bit need, exp_stall, acc;
    int ea, eb, epd, epo;
    @(negedge clk);
    in_valid = iv; src_a = 5'(a); src_b = 5'(b); dst_en = de; dst = 5'(d);
    rel_valid = rv; rel_preg = 6'(rp);
    need = de && (d != 0);
    exp_stall = iv && need && (fc == 0);
    acc = iv && !exp_stall;
    ea = mmap[a]; eb = mmap[b]; epd = 0; epo = 0;
    #1;
    check("R6 stall", int'(stall), int'(exp_stall));
    if (acc && need) begin
      epd = fq[fh]; epo = mmap[d];
      mmap[d] = epd; fh = (fh + 1) % 32; fc--;
      pool[pool_n] = epo; pool_n++;
    end
    if (rv) begin fq[ft] = rp; ft = (ft + 1) % 32; fc++; end
    @(posedge clk); #1;
    check("R8 out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      check("R2 psrc_a", int'(out_psrc_a), ea);
      check("R2 psrc_b", int'(out_psrc_b), eb);
      check("R5 dst_en", int'(out_dst_en), int'(need));
      check("R3 pdst", int'(out_pdst), epd);
      check("R4 pold", int'(out_pold), epo);
      last_pdst = int'(out_pdst);
    end
  endtask

  task automatic rand_release(output bit rv, output int rp);
    rv = 0; rp = 0;
    if (pool_n > 0 && ($urandom % 3) == 0) begin
      int k = $urandom % pool_n;
      rv = 1; rp = pool[k];
      pool[k] = pool[pool_n - 1]; pool_n--;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit rv; int rp;
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R8 reset out_valid", int'(out_valid), 0);
    check("R6 reset stall", int'(stall), 0);

    // R1: identity map after reset
    step(1, 5, 17, 0, 0, 0, 0);
    check("R1 src5", int'(out_psrc_a), 5);
    check("R1 src17", int'(out_psrc_b), 17);
    // R2/R3/R4: read and write the same register
    step(1, 3, 3, 1, 3, 0, 0);
    check("R2 old src", int'(out_psrc_a), 3);
    check("R3 first alloc", int'(out_pdst), 32);
    check("R4 pold", int'(out_pold), 3);
    step(1, 3, 0, 0, 0, 0, 0);
    check("R2 new map", int'(out_psrc_a), 32);
    check("R5 src0", int'(out_psrc_b), 0);
    // R5: destination 0 takes nothing
    step(1, 1, 2, 1, 0, 0, 0);
    check("R5 dst0 en", int'(out_dst_en), 0);
    step(1, 1, 2, 1, 9, 0, 0);
    check("R3 next alloc", int'(out_pdst), 33);
    step(0, 0, 0, 0, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      rand_release(rv, rp);
      step(($urandom % 8) != 0, $urandom % 32, $urandom % 32,
           ($urandom % 4) != 0, $urandom % 32, rv, rp);
    end

    // Drain until empty (no releases)
    for (int n = 0; n < 40; n++) step(1, n % 32, 7, 1, 1 + n % 31, 0, 0);
    check("R6 empty list", fc, 0);
    step(1, 4, 5, 1, 6, 0, 0);
    check("R6 stalled no output", int'(out_valid), 0);
    step(1, 6, 4, 0, 0, 0, 0);
    check("R9 no-dst passes", int'(out_valid), 1);
    // R7: released register is the next one handed out; release while empty
    begin
      int r = pool[0];
      pool[0] = pool[pool_n - 1]; pool_n--;
      step(1, 2, 2, 1, 11, 1, r);
      check("R7 stall at release", int'(out_valid), 0);
      step(1, 2, 2, 1, 11, 0, 0);
      check("R7 reuse", last_pdst, r);
    end
    for (int n = 0; n < 500; n++) begin
      rand_release(rv, rp);
      step(1, $urandom % 32, $urandom % 32, 1, $urandom % 32, rv, rp);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule